// File: doc/BRIEF.md
# I2C SCL-Low Timeout Watchdog

This block limits how long the clock line of an I2C master may sit low while the master engine has work in progress. Software writes one configuration byte. Its least significant bit turns the guard on. The upper seven bits give a limit in coarse ticks. A prescaler turns the system clock into those ticks, sized so that one count lasts about 256 periods of a 57.6 kHz base rate, which is roughly 4.44 ms.

Whenever the engine's state machine changes state, a down-counter is reloaded from the limit. The counter counts ticks only while the guard is on, the engine is busy and SCL is low. When it runs out, the block sends the engine a one-cycle request to return to idle. It also switches its status output to the timeout code 0xF8 and keeps it there until the next command starts.

Top module: `i2c_scl_timeout_wdt`

## Requirements
- R1: The configuration byte is stored on a cycle with `cfg_wr_i` high. Bit 0 enables the guard (1 = on, 0 = off) and bits 7:1 hold the limit L. With bit 0 at 0, `fsm_rst_o` never pulses.
- R2: A cycle with `state_chg_i` high, while enabled and busy, reloads the counter with L and restarts the prescaler.
- R3: The counter and the prescaler advance only on cycles where the guard is enabled, `busy_i` is 1 and `scl_i` is 0. Both hold their values on cycles with `scl_i` at 1.
- R4: One tick takes TICK_DIV counting cycles. Expiry happens on the (L+1)-th tick after a reload. With TICK_DIV = 4, a strobe sampled at edge k gives expiry at edge k + 4·(L+1), plus one cycle for every cycle SCL spends high in between. L = 0 expires on the first tick.
- R5: `fsm_rst_o` is high for exactly one cycle, in the cycle after the expiry edge.
- R6: `status_o` reads 0xF0 (no timeout) until an expiry, then 0xF8. It keeps 0xF8 until a cycle with `cmd_start_i` high, which returns it to 0xF0. If an expiry and `cmd_start_i` fall on the same edge, the result is 0xF8.
- R7: While `busy_i` is 0 the counter stays parked at L and no expiry occurs, whatever the level of `scl_i`.
- R8: After reset `fsm_rst_o` is 0, `status_o` is 0xF0 and the configuration is 0x00, so the guard is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the configuration byte |
| cfg_data_i | input | 8 | Configuration byte: limit in 7:1, enable in 0 |
| state_chg_i | input | 1 | Pulse on each state change of the I2C engine |
| cmd_start_i | input | 1 | Pulse when a new command starts; clears the timeout status |
| scl_i | input | 1 | Sampled SCL level |
| busy_i | input | 1 | High while the I2C engine is running |
| fsm_rst_o | output | 1 | One-cycle request to send the engine back to idle |
| status_o | output | 8 | 0xF0 with no timeout, 0xF8 after a timeout |

## Verification
Some rules are checked on every cycle. A reset request is one cycle wide and comes only after a counting cycle. Status goes to 0xF8 together with the request and stays there until a command starts. A strobe reloads the counter with the limit. The counter is frozen while SCL is high, may fall by no more than one step per cycle, and sits parked at the limit while the engine is idle.

Other behaviour only the bench scenarios can show, because it depends on whole sequences of stimulus:
- the exact expiry cycle for several limits, including 0 and the largest value;
- how far an SCL-high pause or a second strobe moves that cycle;
- that nothing fires while the guard is off or the engine is idle;
- which side wins when expiry and a command start fall on the same edge.

// File: rtl/i2c_wdt_pkg.sv
package i2c_wdt_pkg;
  localparam int unsigned LIMIT_W = 7;

  localparam logic [7:0] ST_OK      = 8'hF0;
  localparam logic [7:0] ST_TIMEOUT = 8'hF8;

  typedef struct packed {
    logic [LIMIT_W-1:0] limit;
    logic               en;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import i2c_wdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [7:0]         data_i,
  output logic               en_o,
  output logic [LIMIT_W-1:0] limit_o
);
  wdt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdt_cfg_t'(data_i);
  end

  assign en_o    = cfg_q.en;
  assign limit_o = cfg_q.limit;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= at_last ? '0 : pre_q + 1'b1;
  end

  assign tick_o = run_i && !clr_i && at_last;
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
  import i2c_wdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               park_i,
  input  logic               reload_i,
  input  logic               tick_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [LIMIT_W-1:0] cnt_o,
  output logic               expire_o
);
  logic [LIMIT_W-1:0] cnt_q;

  // reload has priority over a coincident tick
  assign expire_o = tick_i && !park_i && !reload_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (park_i || reload_i || expire_o) cnt_q <= limit_i;
    else if (tick_i)                       cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import i2c_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       cmd_start_i,
  output logic       rst_req_o,
  output logic [7:0] status_o
);
  logic       req_q;
  logic [7:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      stat_q <= ST_OK;
    end else begin
      req_q <= expire_i;
      if (expire_i)         stat_q <= ST_TIMEOUT;
      else if (cmd_start_i) stat_q <= ST_OK;
    end
  end

  assign rst_req_o = req_q;
  assign status_o  = stat_q;
endmodule

// File: rtl/i2c_scl_timeout_wdt.sv
module i2c_scl_timeout_wdt
  import i2c_wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 14_745_600,
  parameter int unsigned BASE_HZ        = 57_600,
  parameter int unsigned BASE_PER_COUNT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_data_i,
  input  logic       state_chg_i,
  input  logic       cmd_start_i,
  input  logic       scl_i,
  input  logic       busy_i,
  output logic       fsm_rst_o,
  output logic [7:0] status_o
);
  localparam int unsigned TICK_DIV = (CLK_HZ / BASE_HZ) * BASE_PER_COUNT;

  logic               cfg_en;
  logic [LIMIT_W-1:0] cfg_limit;
  logic               active, run, tick, expire;
  logic [LIMIT_W-1:0] cnt;

  assign active = cfg_en && busy_i;
  assign run    = active && !scl_i;

  wdt_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_wr_i),
    .data_i  (cfg_data_i),
    .en_o    (cfg_en),
    .limit_o (cfg_limit)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!active || state_chg_i),
    .run_i  (run),
    .tick_o (tick)
  );

  wdt_down_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .park_i   (!active),
    .reload_i (state_chg_i),
    .tick_i   (tick),
    .limit_i  (cfg_limit),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdt_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .expire_i    (expire),
    .cmd_start_i (cmd_start_i),
    .rst_req_o   (fsm_rst_o),
    .status_o    (status_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import i2c_wdt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_i,
  input logic               scl_i,
  input logic               state_chg_i,
  input logic               cmd_start_i,
  input logic               en,
  input logic [LIMIT_W-1:0] limit,
  input logic [LIMIT_W-1:0] cnt,
  input logic               fsm_rst_o,
  input logic [7:0]         status_o
);
  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_o |=> !fsm_rst_o);

  p_pulse_after_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_o |-> $past(en && busy_i && !scl_i));

  p_status_on_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_o |-> status_o == ST_TIMEOUT);

  p_status_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_TIMEOUT && !cmd_start_i) |=> status_o == ST_TIMEOUT);

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && busy_i && state_chg_i) |=> cnt == $past(limit));

  p_hold_scl_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && busy_i && scl_i && !state_chg_i) |=> $stable(cnt));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && busy_i && !scl_i && !state_chg_i) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == $past(limit)));

  p_idle_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (cnt == $past(limit) && !fsm_rst_o));

  p_disabled_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !fsm_rst_o);
endmodule

bind i2c_scl_timeout_wdt wdt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .scl_i       (scl_i),
  .state_chg_i (state_chg_i),
  .cmd_start_i (cmd_start_i),
  .en          (cfg_en),
  .limit       (cfg_limit),
  .cnt         (cnt),
  .fsm_rst_o   (fsm_rst_o),
  .status_o    (status_o)
);

// File: tb/test_i2c_scl_timeout_wdt.sv
module test_i2c_scl_timeout_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       state_chg = 1'b0;
  logic       cmd_start = 1'b0;
  logic       scl = 1'b1;
  logic       busy = 1'b0;
  logic       fsm_rst;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 1'b0;
  bit prev_rst = 1'b0;

  i2c_scl_timeout_wdt #(.CLK_HZ(8), .BASE_HZ(2), .BASE_PER_COUNT(1)) i_i2c_scl_timeout_wdt (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_wr_i    (cfg_wr),
    .cfg_data_i  (cfg_data),
    .state_chg_i (state_chg),
    .cmd_start_i (cmd_start),
    .scl_i       (scl),
    .busy_i      (busy),
    .fsm_rst_o   (fsm_rst),
    .status_o    (status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected pulse cycles
  always @(negedge clk) begin
    if (rst_n) begin
      if (fsm_rst) begin
        if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected reset pulse at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4", "expiry cycle", cyc, e);
          chk(status == 8'hF8, "R6", "status with pulse", status, 8'hF8);
        end
        chk(!prev_rst, "R5", "pulse width", prev_rst, 0);
      end
      prev_rst = fsm_rst;
    end
  end

  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk); cfg_data = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic run_to(input int v, input int pause_len, input int restrobe_at, input bit clash);
    int e;
    int n;
    wr_cfg({v[6:0], 1'b1});
    @(negedge clk);
    n = cyc; busy = 1'b1; scl = 1'b0; state_chg = 1'b1;
    e = n + 1 + TDIV*(v+1);
    @(negedge clk); state_chg = 1'b0;
    if (restrobe_at > 0) begin
      repeat (restrobe_at-1) @(negedge clk);
      state_chg = 1'b1;
      e = cyc + 1 + TDIV*(v+1);  // R2 reload restarts the window
      @(negedge clk); state_chg = 1'b0;
    end
    if (pause_len > 0) begin
      @(negedge clk); scl = 1'b1;
      repeat (pause_len) @(negedge clk);
      scl = 1'b0;
      e += pause_len;            // R3 hold while SCL high
    end
    exp_q.push_back(e);
    if (clash) begin
      while (cyc < e-1) @(negedge clk);
      cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
    end else begin
      while (cyc < e) @(negedge clk);
    end
    busy = 1'b0; scl = 1'b1;
    @(negedge clk);
    chk(fsm_rst == 1'b0, "R5", "pulse dropped", fsm_rst, 0);
    chk(status == 8'hF8, "R6", "status after timeout", status, 8'hF8);
    repeat (3) @(negedge clk);
    chk(status == 8'hF8, "R6", "status held", status, 8'hF8);
    cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    chk(status == 8'hF0, "R6", "status cleared by command", status, 8'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fsm_rst == 1'b0, "R8", "reset pulse", fsm_rst, 0);
    chk(status == 8'hF0, "R8", "reset status", status, 8'hF0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 config is zero: guard off, no expiry
    busy = 1'b1; scl = 1'b0;
    repeat (20) @(negedge clk);
    chk(status == 8'hF0, "R8", "guard off after reset", status, 8'hF0);
    busy = 1'b0; scl = 1'b1;

    run_to(0, 0, 0, 1'b0);    // R4 zero limit
    run_to(3, 0, 0, 1'b0);    // R4
    run_to(5, 7, 0, 1'b0);    // R3 pause
    run_to(4, 0, 9, 1'b0);    // R2 restrobe
    run_to(2, 0, 0, 1'b1);    // R6 clash
    run_to(127, 0, 0, 1'b0);  // R4 max limit

    // R1 disabled guard with nonzero limit
    wr_cfg(8'h06);
    @(negedge clk); busy = 1'b1; scl = 1'b0; state_chg = 1'b1;
    @(negedge clk); state_chg = 1'b0;
    repeat (60) @(negedge clk);
    chk(status == 8'hF0, "R1", "disabled guard status", status, 8'hF0);
    busy = 1'b0; scl = 1'b1;

    // R7 idle engine, SCL low, enabled with limit 0
    wr_cfg(8'h01);
    @(negedge clk); busy = 1'b0; scl = 1'b0;
    repeat (60) @(negedge clk);
    chk(status == 8'hF0, "R7", "idle engine status", status, 8'hF0);
    scl = 1'b1;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "missing pulses", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R4", "watchdog expired at cycle", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule